// File: doc/BRIEF.md
# Window-Select Barrel Shifter

This block shifts or rotates an N-bit word by any amount from 0 to N-1 in a single pass of combinational logic, with no iteration and no clock. Inside, the word is placed into a 2N-bit field made of a high half and a low half. The mode decides what fills each half. A one-hot column select then picks one contiguous N-bit window out of that field. The binary shift amount is decoded into the column select inside the block.

The data path is a stream stage with no storage. A word is offered with `in_valid`. It appears on `out_data` in the same cycle, with `out_valid` equal to `in_valid`. Back-pressure passes straight through: `in_ready` follows `out_ready`. A word is accepted only in a cycle where both `in_valid` and `out_ready` are high. The upstream side must hold the data, mode and amount steady until that cycle. `out_data` is meaningful only while `out_valid` is high. N must be a power of two, so every value of the amount field is a legal shift.

Top module: `barrel_window_shifter`

## Requirements
- R1: With mode code 2'b00 (logical right), `out_data` equals `in_data >> in_amt`, and the top `in_amt` bits are zero.
- R2: With mode code 2'b01 (logical left), `out_data` equals `in_data << in_amt`, and the bottom `in_amt` bits are zero.
- R3: With mode code 2'b10 (rotate right), bit i of `out_data` equals bit (i + `in_amt`) mod N of `in_data`.
- R4: With mode code 2'b11, `out_data` is all zeros for every data word and every amount.
- R5: For mode codes 2'b00, 2'b01 and 2'b10, an amount of 0 passes `in_data` to `out_data` unchanged.
- R6: Exactly one window column is selected for any amount. The result reflects the current inputs within the same cycle, with no register on the path.
- R7: `out_valid` always equals `in_valid`, and `in_ready` always equals `out_ready`. Neither depends on the data, the mode or the amount.
- R8: In rotate mode, `out_data` has the same number of ones as `in_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Upstream offers a word |
| in_ready | output | 1 | Block can accept; follows `out_ready` |
| in_data | input | N | Word to shift |
| in_mode | input | 2 | 00 right, 01 left, 10 rotate right, 11 zero |
| in_amt | input | log2(N) | Binary shift amount |
| out_valid | output | 1 | Result present; follows `in_valid` |
| out_ready | input | 1 | Downstream can take the result |
| out_data | output | N | Shifted or rotated word |

## Verification
The assertions take for granted that the inputs carry known 0/1 values whenever they are sampled. They also take for granted that the amount field cannot name a shift of N or more, which holds because N is a power of two. The checks are immediate, so they also assume the combinational inputs have settled before they are evaluated. The stimulus drives only defined values. It changes inputs on one clock edge and observes half a period later. It draws amounts from the full field width, so every legal column is reached, and it covers every mode code, including the reserved zero code.

// File: rtl/bsh_pkg.sv
`timescale 1ns/1ps
package bsh_pkg;
  // Mode codes; the fill pattern of the two halves depends on these values.
  typedef enum logic [1:0] {
    BSH_SHR  = 2'b00,
    BSH_SHL  = 2'b01,
    BSH_ROR  = 2'b10,
    BSH_ZERO = 2'b11
  } bsh_mode_e;
endpackage

// File: rtl/bsh_col_decode.sv
`timescale 1ns/1ps
// Binary column index to one-hot column select.
module bsh_col_decode #(
  parameter int N  = 32,
  parameter int SW = $clog2(N)
) (
  input  logic [SW-1:0] col_idx,
  output logic [N-1:0]  col_sel
);
  for (genvar k = 0; k < N; k++) begin : g_col
    assign col_sel[k] = (col_idx == SW'(k));
  end
endmodule

// File: rtl/bsh_half_fill.sv
`timescale 1ns/1ps
// Chooses what drives the high and low halves of the 2N-bit field.
module bsh_half_fill
  import bsh_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] data,
  input  bsh_mode_e    mode,
  input  logic         amt_zero,
  output logic [N-1:0] half_hi,
  output logic [N-1:0] half_lo
);
  always_comb begin
    half_hi = '0;
    half_lo = '0;
    unique case (mode)
      BSH_SHR: half_lo = data;
      BSH_SHL: begin
        half_hi = data;
        // Zero amount folds onto column 0, which reads the low half.
        if (amt_zero) half_lo = data;
      end
      BSH_ROR: begin
        half_hi = data;
        half_lo = data;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bsh_window_array.sv
`timescale 1ns/1ps
// Grid of N columns by N rows: output bit i takes field bit i+k when column k is on.
module bsh_window_array #(
  parameter int N = 32
) (
  input  logic [N-1:0] half_hi,
  input  logic [N-1:0] half_lo,
  input  logic [N-1:0] col_sel,
  output logic [N-1:0] win
);
  localparam int FW = 2 * N;
  logic [FW-1:0] field;
  assign field = {half_hi, half_lo};

  for (genvar i = 0; i < N; i++) begin : g_row
    logic [N-1:0] tap;
    for (genvar k = 0; k < N; k++) begin : g_cell
      assign tap[k] = col_sel[k] & field[i + k];
    end
    assign win[i] = |tap;
  end
endmodule

// File: rtl/barrel_window_shifter.sv
`timescale 1ns/1ps
module barrel_window_shifter
  import bsh_pkg::*;
#(
  parameter int N  = 32,
  parameter int SW = $clog2(N)
) (
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N-1:0]  in_data,
  input  logic [1:0]    in_mode,
  input  logic [SW-1:0] in_amt,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [N-1:0]  out_data
);
  if ((1 << SW) != N || N < 2) begin : g_bad_width
    $error("barrel_window_shifter: N must be a power of two of at least 2");
  end

  bsh_mode_e     mode;
  logic [SW-1:0] col_idx;
  logic [N-1:0]  col_sel;
  logic [N-1:0]  half_hi;
  logic [N-1:0]  half_lo;
  logic          amt_zero;

  assign mode     = bsh_mode_e'(in_mode);
  assign amt_zero = (in_amt == '0);
  // Left shift reads the window from column (N - amt) mod N.
  assign col_idx  = (mode == BSH_SHL) ? (SW'(0) - in_amt) : in_amt;

  bsh_col_decode #(.N(N), .SW(SW)) u_decode (
    .col_idx (col_idx),
    .col_sel (col_sel)
  );

  bsh_half_fill #(.N(N)) u_fill (
    .data     (in_data),
    .mode     (mode),
    .amt_zero (amt_zero),
    .half_hi  (half_hi),
    .half_lo  (half_lo)
  );

  bsh_window_array #(.N(N)) u_array (
    .half_hi (half_hi),
    .half_lo (half_lo),
    .col_sel (col_sel),
    .win     (out_data)
  );

  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/bsh_checker.sv
`timescale 1ns/1ps
module bsh_checker #(
  parameter int N  = 32,
  parameter int SW = $clog2(N)
) (
  input logic          in_valid,
  input logic          in_ready,
  input logic [N-1:0]  in_data,
  input logic [1:0]    in_mode,
  input logic [SW-1:0] in_amt,
  input logic          out_valid,
  input logic          out_ready,
  input logic [N-1:0]  out_data,
  input logic [N-1:0]  col_sel
);
  always_comb begin
    p_onehot_col_r6: assert ($onehot(col_sel))
      else $error("column select not one-hot");
    p_handshake_pass_r7: assert (out_valid == in_valid && in_ready == out_ready)
      else $error("handshake not passed through");
    if (in_valid) begin
      p_zero_amt_pass_r5: assert (!(in_amt == '0 && in_mode != 2'b11) || out_data == in_data)
        else $error("zero amount altered data");
      p_zero_code_r4: assert (in_mode != 2'b11 || out_data == '0)
        else $error("reserved mode produced ones");
      p_rot_popcount_r8: assert (in_mode != 2'b10 || $countones(out_data) == $countones(in_data))
        else $error("rotate changed population count");
      p_shr_msb_r1: assert (!(in_mode == 2'b00 && in_amt != '0) || !out_data[N-1])
        else $error("right shift did not clear top bit");
      p_shl_lsb_r2: assert (!(in_mode == 2'b01 && in_amt != '0) || !out_data[0])
        else $error("left shift did not clear bottom bit");
      p_ror_bit0_r3: assert (in_mode != 2'b10 || out_data[0] == in_data[in_amt])
        else $error("rotate bit 0 wrong");
    end
  end
endmodule

bind barrel_window_shifter bsh_checker #(.N(N), .SW(SW)) u_bsh_checker (
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_mode   (in_mode),
  .in_amt    (in_amt),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .col_sel   (col_sel)
);

// File: tb/tb_barrel_window_shifter.sv
`timescale 1ns/1ps
module tb_barrel_window_shifter;
  localparam int N  = 32;
  localparam int SW = $clog2(N);

  logic          clk = 1'b0;
  logic          in_valid, in_ready, out_valid, out_ready;
  logic [N-1:0]  in_data, out_data;
  logic [1:0]    in_mode;
  logic [SW-1:0] in_amt;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  barrel_window_shifter #(.N(N), .SW(SW)) dut (
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .in_mode (in_mode), .in_amt (in_amt), .out_valid (out_valid),
    .out_ready (out_ready), .out_data (out_data)
  );

  function automatic logic [N-1:0] ref_fn(logic [N-1:0] d, logic [1:0] m, int s);
    case (m)
      2'b00: return d >> s;
      2'b01: return d << s;
      2'b10: return (s == 0) ? d : ((d >> s) | (d << (N - s)));
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(logic [1:0] m, int s);
    if (m == 2'b11) return "R4";
    if (s == 0) return "R5";
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a rising edge, observe half a period later (same cycle, no register: R6).
  task automatic apply(logic [N-1:0] d, logic [1:0] m, int s, logic rdy);
    @(posedge clk);
    in_valid  <= 1'b1;
    in_data   <= d;
    in_mode   <= m;
    in_amt    <= SW'(s);
    out_ready <= rdy;
    @(negedge clk);
    check(req_of(m, s), out_data, ref_fn(d, m, s));
    check("R7", {30'd0, out_valid, in_ready}, {30'd0, 1'b1, rdy});
    if (m == 2'b10)
      check("R8", N'($countones(out_data)), N'($countones(d)));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    void'($urandom(32'd1234));
    in_valid = 1'b0; out_ready = 1'b0; in_data = '0; in_mode = 2'b00; in_amt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7", {30'd0, out_valid, in_ready}, 32'd0);   // idle state

    // Directed corners: every mode at amounts 0, 1, N-1 on several patterns.
    for (int m = 0; m < 4; m++) begin
      apply({N{1'b1}}, 2'(m), 0, 1'b1);
      apply({N{1'b1}}, 2'(m), 1, 1'b0);
      apply({N{1'b1}}, 2'(m), N - 1, 1'b1);
      apply({(N/2){2'b10}}, 2'(m), 1, 1'b1);
      apply(N'(1), 2'(m), N - 1, 1'b0);
      apply({1'b1, {(N-1){1'b0}}}, 2'(m), N - 1, 1'b1);
    end
    // R6: change inputs mid-cycle, result follows without a clock edge.
    @(posedge clk);
    in_data = 32'h8000_0001; in_mode = 2'b10; in_amt = SW'(4);
    #1;
    check("R6", out_data, ref_fn(32'h8000_0001, 2'b10, 4));
    in_amt = SW'(5);
    #1;
    check("R6", out_data, ref_fn(32'h8000_0001, 2'b10, 5));

    // Random sweep, every amount hit per mode.
    for (int n = 0; n < 3000; n++) begin
      d = $urandom();
      apply(d, 2'($urandom_range(3)), int'($urandom_range(N - 1)), 1'($urandom()));
    end
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < N; s++)
        apply($urandom(), 2'(m), s, 1'b1);

    @(posedge clk);
    in_valid <= 1'b0;
    @(negedge clk);
    check("R7", {31'd0, out_valid}, 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule